// File: doc/BRIEF.md
# Per-Entry Cache Line Location and Translation Reuse

This block sits beside a banked, address-grouped load/store queue in which every queue entry holds several memory operations that all touch one cache line. When an entry's first operation performs a complete cache access, the block keeps three things in that entry: the set and way where the line was found, and the page translation. Later operations from the same entry then take a reduced path. They read one way of the data array, with no tag compare and no TLB lookup. Each request is tagged with the entry index. The block answers in the same cycle with either "full access" or "reduced access", and for a reduced access it also gives the cached set, way and translation.

A matching present bit is kept for each cache line, so the eviction of a line can be recognised. When such a line is replaced, the block does not compare any addresses. It clears the cached state of every entry that could hold that line: the entries of the queue bank that the replaced set maps to, and every overflow entry. Freeing an entry also clears its cached state.

The queue has `NumBanks` banks of `EntPerBank` entries. Entry index `i < NumBanks*EntPerBank` belongs to bank `i / EntPerBank`. Higher indices are overflow entries. A cache set `s` maps to bank `s mod NumBanks`, which is the low bits of the set index.

Top module: `line_loc_reuse`

## Requirements
- R1: After reset no entry and no line holds cached state. Any valid request gives `reqFull`=1 and `reqReduced`=0, and `replFlush` stays 0.
- R2: A `fillValid` pulse records its set, way and translation for `fillEntry` at the clock edge. From the next cycle a request on that entry gives `reqReduced`=1 and `reqFull`=0, with `reqSet`, `reqWay` and `reqPpn` equal to the recorded values.
- R3: Cached state belongs to one entry. A request on any other entry that has had no fill still gives a full access.
- R4: A fill also sets the present bit of line {set,way}. A replacement of a line whose bit is set raises `replFlush` in the same cycle and clears that line bit. A second replacement of the same line with no new fill in between gives `replFlush`=0.
- R5: A flushing replacement of set `s` clears the cached state of every entry in bank `s mod NumBanks` and of every overflow entry, whatever line they hold. Entries of other banks keep their state.
- R6: A replacement of a line whose present bit is clear changes no entry's state, even when an entry in the mapped bank holds another way of the same set.
- R7: A request whose cached line is being replaced in the same cycle gives `reqFull`=1 and `reqReduced`=0.
- R8: `freeValid` clears the cached state of `freeEntry`. If a fill and a free name the same entry in the same cycle, the free wins.
- R9: A fill whose line is replaced in the same cycle is discarded. The entry keeps giving full accesses and the line bit stays clear.
- R10: When `reqReduced`=0, the outputs `reqSet`, `reqWay` and `reqPpn` are zero. A request with `reqValid`=0 gives neither `reqFull` nor `reqReduced`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | An access request is presented |
| reqEntry | input | EntW | Queue entry issuing the request |
| reqFull | output | 1 | Request must do TLB lookup, tag check and all-way read |
| reqReduced | output | 1 | Request may read only the cached way |
| reqSet | output | SetW | Cached set for a reduced access |
| reqWay | output | WayW | Cached way for a reduced access |
| reqPpn | output | PpnW | Cached translation for a reduced access |
| fillValid | input | 1 | Result of a full access is returned |
| fillEntry | input | EntW | Entry that made the full access |
| fillSet | input | SetW | Set where the line was found |
| fillWay | input | WayW | Way where the line was found |
| fillPpn | input | PpnW | Translation from the TLB |
| replValid | input | 1 | A cache line is being replaced |
| replSet | input | SetW | Set of the replaced line |
| replWay | input | WayW | Way of the replaced line |
| replFlush | output | 1 | Replaced line was marked present; entries are cleared |
| freeValid | input | 1 | A queue entry is released |
| freeEntry | input | EntW | Entry being released |

## Verification
The most serious internal fault is stale location state. If it occurs, `reqReduced` is raised for a line that has been evicted, and the reduced read then returns data from a line that has been replaced. The bench makes this visible in the cycle right after each replacement or free: it requests every entry that could be affected and every neighbour that must not be. A lost line bit shows up as a missing `replFlush` on the very replacement that should have cleared the bank. A conflict in the same cycle only shows in the cycle where replacement and request coincide, so that cycle is sampled directly.

// File: rtl/llc_pkg.sv
package llc_pkg;
  localparam int NumBanks   = 4;
  localparam int EntPerBank = 2;
  localparam int NumShared  = 2;
  localparam int NumSets    = 16;
  localparam int NumWays    = 4;
  localparam int PpnW       = 12;

  localparam int NumBankEnt = NumBanks * EntPerBank;
  localparam int NumEnt     = NumBankEnt + NumShared;
  localparam int EntW       = $clog2(NumEnt);
  localparam int SetW       = $clog2(NumSets);
  localparam int WayW       = $clog2(NumWays);
  localparam int BankW      = $clog2(NumBanks);
  localparam int LineW      = SetW + WayW;
  localparam int NumLines   = NumSets * NumWays;

  typedef struct packed {
    logic              capture;
    logic [NumEnt-1:0] clrMask;
    logic              lineSet;
    logic              lineClr;
  } strobe_t;
endpackage

// File: rtl/llc_ctrl.sv
module llc_ctrl
  import llc_pkg::*;
(
  input  logic            reqValid,
  input  logic            rdPresent,
  input  logic [SetW-1:0] rdSet,
  input  logic [WayW-1:0] rdWay,
  input  logic            replValid,
  input  logic [SetW-1:0] replSet,
  input  logic [WayW-1:0] replWay,
  input  logic            replLineBit,
  input  logic            fillValid,
  input  logic [EntW-1:0] fillEntry,
  input  logic [SetW-1:0] fillSet,
  input  logic [WayW-1:0] fillWay,
  input  logic            freeValid,
  input  logic [EntW-1:0] freeEntry,
  output strobe_t         stb,
  output logic            reqFull,
  output logic            reqReduced,
  output logic            replFlush
);
  logic replHitsReq;
  logic replHitsFill;
  logic freeSameAsFill;

  // a reduced read of a line being evicted this cycle falls back to full
  assign replHitsReq = replValid && (rdSet == replSet) && (rdWay == replWay);
  assign reqReduced  = reqValid && rdPresent && !replHitsReq;
  assign reqFull     = reqValid && !reqReduced;

  assign replFlush      = replValid && replLineBit;
  assign replHitsFill   = replValid && (fillSet == replSet) && (fillWay == replWay);
  assign freeSameAsFill = freeValid && (freeEntry == fillEntry);

  assign stb.capture = fillValid && !replHitsFill && !freeSameAsFill;
  assign stb.lineSet = stb.capture;
  assign stb.lineClr = replFlush;

  // conservative clear: whole mapped bank plus every overflow entry
  for (genvar e = 0; e < NumEnt; e++) begin : g_clr
    logic affected;
    if (e < NumBankEnt) begin : g_bank
      localparam logic [BankW-1:0] BankId = BankW'(e / EntPerBank);
      assign affected = (replSet[BankW-1:0] == BankId);
    end else begin : g_shared
      assign affected = 1'b1;
    end
    assign stb.clrMask[e] = (replFlush && affected) ||
                            (freeValid && (freeEntry == EntW'(e)));
  end
endmodule

// File: rtl/llc_datapath.sv
module llc_datapath
  import llc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [EntW-1:0] reqEntry,
  input  logic [EntW-1:0] fillEntry,
  input  logic [SetW-1:0] fillSet,
  input  logic [WayW-1:0] fillWay,
  input  logic [PpnW-1:0] fillPpn,
  input  logic [SetW-1:0] replSet,
  input  logic [WayW-1:0] replWay,
  output logic            rdPresent,
  output logic [SetW-1:0] rdSet,
  output logic [WayW-1:0] rdWay,
  output logic [PpnW-1:0] rdPpn,
  output logic            replLineBit
);
  logic [NumEnt-1:0]   entPresent;
  logic [SetW-1:0]     entSet [NumEnt];
  logic [WayW-1:0]     entWay [NumEnt];
  logic [PpnW-1:0]     entPpn [NumEnt];
  logic [NumLines-1:0] lineBit;

  logic [LineW-1:0] fillLine;
  logic [LineW-1:0] replLine;
  logic             rdInRange;

  assign fillLine  = {fillSet, fillWay};
  assign replLine  = {replSet, replWay};
  assign rdInRange = (32'(reqEntry) < NumEnt);

  always_ff @(posedge clk) begin
    for (int e = 0; e < NumEnt; e++) begin
      if (!rstN) begin
        entPresent[e] <= 1'b0;
        entSet[e]     <= '0;
        entWay[e]     <= '0;
        entPpn[e]     <= '0;
      end else if (stb.capture && (fillEntry == EntW'(e))) begin
        entPresent[e] <= 1'b1;
        entSet[e]     <= fillSet;
        entWay[e]     <= fillWay;
        entPpn[e]     <= fillPpn;
      end else if (stb.clrMask[e]) begin
        entPresent[e] <= 1'b0;
        entSet[e]     <= '0;
        entWay[e]     <= '0;
        entPpn[e]     <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < NumLines; l++) begin
      if (!rstN) lineBit[l] <= 1'b0;
      else if (stb.lineSet && (fillLine == LineW'(l))) lineBit[l] <= 1'b1;
      else if (stb.lineClr && (replLine == LineW'(l))) lineBit[l] <= 1'b0;
    end
  end

  always_comb begin
    rdPresent = 1'b0;
    rdSet     = '0;
    rdWay     = '0;
    rdPpn     = '0;
    if (rdInRange) begin
      rdPresent = entPresent[reqEntry];
      rdSet     = entSet[reqEntry];
      rdWay     = entWay[reqEntry];
      rdPpn     = entPpn[reqEntry];
    end
  end

  assign replLineBit = lineBit[replLine];
endmodule

// File: rtl/line_loc_reuse.sv
module line_loc_reuse
  import llc_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [EntW-1:0] reqEntry,
  output logic            reqFull,
  output logic            reqReduced,
  output logic [SetW-1:0] reqSet,
  output logic [WayW-1:0] reqWay,
  output logic [PpnW-1:0] reqPpn,
  input  logic            fillValid,
  input  logic [EntW-1:0] fillEntry,
  input  logic [SetW-1:0] fillSet,
  input  logic [WayW-1:0] fillWay,
  input  logic [PpnW-1:0] fillPpn,
  input  logic            replValid,
  input  logic [SetW-1:0] replSet,
  input  logic [WayW-1:0] replWay,
  output logic            replFlush,
  input  logic            freeValid,
  input  logic [EntW-1:0] freeEntry
);
  strobe_t         stb;
  logic            rdPresent;
  logic [SetW-1:0] rdSet;
  logic [WayW-1:0] rdWay;
  logic [PpnW-1:0] rdPpn;
  logic            replLineBit;

  llc_ctrl i_ctrl (
    .reqValid(reqValid), .rdPresent(rdPresent), .rdSet(rdSet), .rdWay(rdWay),
    .replValid(replValid), .replSet(replSet), .replWay(replWay),
    .replLineBit(replLineBit), .fillValid(fillValid), .fillEntry(fillEntry),
    .fillSet(fillSet), .fillWay(fillWay), .freeValid(freeValid),
    .freeEntry(freeEntry), .stb(stb), .reqFull(reqFull),
    .reqReduced(reqReduced), .replFlush(replFlush)
  );

  llc_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqEntry(reqEntry),
    .fillEntry(fillEntry), .fillSet(fillSet), .fillWay(fillWay),
    .fillPpn(fillPpn), .replSet(replSet), .replWay(replWay),
    .rdPresent(rdPresent), .rdSet(rdSet), .rdWay(rdWay), .rdPpn(rdPpn),
    .replLineBit(replLineBit)
  );

  assign reqSet = reqReduced ? rdSet : '0;
  assign reqWay = reqReduced ? rdWay : '0;
  assign reqPpn = reqReduced ? rdPpn : '0;
endmodule

// File: rtl/line_loc_reuse_chk.sv
module line_loc_reuse_chk
  import llc_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [EntW-1:0] reqEntry,
  input logic            reqFull,
  input logic            reqReduced,
  input logic [SetW-1:0] reqSet,
  input logic [WayW-1:0] reqWay,
  input logic            fillValid,
  input logic [EntW-1:0] fillEntry,
  input logic [SetW-1:0] fillSet,
  input logic [WayW-1:0] fillWay,
  input logic            replValid,
  input logic [SetW-1:0] replSet,
  input logic [WayW-1:0] replWay,
  input logic            replFlush,
  input logic            freeValid,
  input logic [EntW-1:0] freeEntry
);
  // R10 / R1: a valid request gets exactly one verdict, an idle one none
  a_r10_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqFull != reqReduced));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (!reqFull && !reqReduced));

  // R2: a clean fill makes the next request on that entry reduced at that line
  a_r2_fill_reuse: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !replValid && !(freeValid && freeEntry == fillEntry))
    |=> ((reqValid && reqEntry == $past(fillEntry) && !replValid && !freeValid)
         |-> (reqReduced && reqSet == $past(fillSet) && reqWay == $past(fillWay))));

  // R7: never a reduced access to the line being replaced this cycle
  a_r7_conflict_full: assert property (@(posedge clk) disable iff (!rstN)
    (replValid && reqReduced) |-> !(reqSet == replSet && reqWay == replWay));

  // R8: a freed entry with no new fill is not reduced in the next cycle
  a_r8_free_clears: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && !(fillValid && fillEntry == freeEntry))
    |=> ((reqValid && reqEntry == $past(freeEntry)) |-> !reqReduced));

  // R4: a flushed line does not flush again without a refill
  a_r4_flush_once: assert property (@(posedge clk) disable iff (!rstN)
    (replFlush && !(fillValid && fillSet == replSet && fillWay == replWay))
    |=> !(replValid && replSet == $past(replSet) && replWay == $past(replWay)
          && replFlush));
endmodule

bind line_loc_reuse line_loc_reuse_chk i_chk (.*);

// File: tb/test_line_loc_reuse.sv
module test_line_loc_reuse;
  import llc_pkg::*;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic [EntW-1:0] reqEntry = '0;
  logic            reqFull, reqReduced, replFlush;
  logic [SetW-1:0] reqSet;
  logic [WayW-1:0] reqWay;
  logic [PpnW-1:0] reqPpn;
  logic            fillValid = 1'b0;
  logic [EntW-1:0] fillEntry = '0;
  logic [SetW-1:0] fillSet = '0;
  logic [WayW-1:0] fillWay = '0;
  logic [PpnW-1:0] fillPpn = '0;
  logic            replValid = 1'b0;
  logic [SetW-1:0] replSet = '0;
  logic [WayW-1:0] replWay = '0;
  logic            freeValid = 1'b0;
  logic [EntW-1:0] freeEntry = '0;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  line_loc_reuse i_line_loc_reuse (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = 0; fillValid = 0; replValid = 0; freeValid = 0;
  endtask

  task automatic fill(input int e, input int s, input int w, input int p);
    @(negedge clk);
    idle();
    fillValid = 1; fillEntry = EntW'(e); fillSet = SetW'(s);
    fillWay = WayW'(w); fillPpn = PpnW'(p);
    @(negedge clk);
    idle();
  endtask

  task automatic replace(input int s, input int w, input int expFlush, input string tag);
    @(negedge clk);
    idle();
    replValid = 1; replSet = SetW'(s); replWay = WayW'(w);
    #2;
    chk(replFlush == expFlush[0], tag, replFlush, expFlush);
    @(negedge clk);
    idle();
  endtask

  // request in the current low phase; expRed=0 means full with zero fields
  task automatic probe(input int e, input int expRed, input int s, input int w,
                       input int p, input string tag);
    reqValid = 1; reqEntry = EntW'(e);
    #2;
    chk(reqReduced == expRed[0] && reqFull == !expRed[0], {tag, " verdict"},
        reqReduced, expRed);
    if (expRed != 0)
      chk(reqSet == SetW'(s) && reqWay == WayW'(w) && reqPpn == PpnW'(p),
          {tag, " fields"}, {reqSet, reqWay, reqPpn}, {SetW'(s), WayW'(w), PpnW'(p)});
    else
      chk(reqSet == 0 && reqWay == 0 && reqPpn == 0, {tag, " R10 zero"},
          {reqSet, reqWay, reqPpn}, 0);
    reqValid = 0;
  endtask

  task automatic probeNow(input int e, input int expRed, input int s, input int w,
                          input int p, input string tag);
    @(negedge clk);
    idle();
    probe(e, expRed, s, w, p, tag);
  endtask

  task automatic tReset();
    @(negedge clk);
    #2;
    chk(!reqFull && !reqReduced, "R10 idle", {reqFull, reqReduced}, 0);
    for (int e = 0; e < NumEnt; e++) probe(e, 0, 0, 0, 0, "R1 reset");
    replace(3, 1, 0, "R1 no flush after reset");
  endtask

  task automatic tFillReuse();
    fill(0, 4, 1, 'h5A);
    probeNow(0, 1, 4, 1, 'h5A, "R2 reuse");
    probeNow(1, 0, 0, 0, 0, "R3 other entry");
    probeNow(8, 0, 0, 0, 0, "R3 overflow entry");
  endtask

  task automatic tBankClear();
    fill(1, 8, 3, 'h111);
    fill(2, 5, 0, 'h222);
    fill(8, 9, 2, 'h333);
    fill(5, 2, 1, 'h444);
    replace(4, 1, 1, "R4 flush on present line");
    probeNow(0, 0, 0, 0, 0, "R5 bank0 entry0 cleared");
    probeNow(1, 0, 0, 0, 0, "R5 bank0 entry1 cleared");
    probeNow(8, 0, 0, 0, 0, "R5 overflow cleared");
    probeNow(2, 1, 5, 0, 'h222, "R5 bank1 kept");
    probeNow(5, 1, 2, 1, 'h444, "R5 bank2 kept");
    replace(4, 1, 0, "R4 second replace no flush");
  endtask

  task automatic tAbsentLine();
    replace(5, 3, 0, "R6 absent line no flush");
    probeNow(2, 1, 5, 0, 'h222, "R6 entry kept");
  endtask

  task automatic tConflict();
    @(negedge clk);
    idle();
    replValid = 1; replSet = 5; replWay = 0;
    probe(2, 0, 0, 0, 0, "R7 same-cycle replace");
    chk(replFlush == 1, "R7 flush seen", replFlush, 1);
    @(negedge clk);
    idle();
    probe(2, 0, 0, 0, 0, "R7 after replace");
  endtask

  task automatic tFree();
    fill(3, 7, 2, 'h777);
    probeNow(3, 1, 7, 2, 'h777, "R8 before free");
    @(negedge clk);
    idle();
    freeValid = 1; freeEntry = 3;
    @(negedge clk);
    idle();
    probe(3, 0, 0, 0, 0, "R8 freed");
    @(negedge clk);
    idle();
    freeValid = 1; freeEntry = 4;
    fillValid = 1; fillEntry = 4; fillSet = 10; fillWay = 1; fillPpn = 'h99;
    @(negedge clk);
    idle();
    probe(4, 0, 0, 0, 0, "R8 free beats fill");
  endtask

  task automatic tFillDropped();
    @(negedge clk);
    idle();
    fillValid = 1; fillEntry = 6; fillSet = 11; fillWay = 3; fillPpn = 'hABC;
    replValid = 1; replSet = 11; replWay = 3;
    @(negedge clk);
    idle();
    probe(6, 0, 0, 0, 0, "R9 fill dropped");
    replace(11, 3, 0, "R9 line bit clear");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    tReset();
    tFillReuse();
    tBankClear();
    tAbsentLine();
    tConflict();
    tFree();
    tFillDropped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule